// File: doc/BRIEF.md
# Dual-Slot TLP Transmit Packer

This block takes transaction layer packets from an upstream source, one packet after another, as beats of up to four dwords. It places them onto a 256-bit transmit stream that has eight dword lanes. A packet starts either in lane 0 or in lane 4. When a packet finishes in the lower 128-bit half of a beat, the next packet can begin in the upper half of that same beat. Short packets therefore waste less of the bus than they would if every packet had to start a new beat.

Incoming dwords go into a small circular dword store. A combinational slot former looks at the oldest eight dwords and decides what the next output beat holds. It chooses the start slot, shifts the next packet's dwords into the upper lanes, and computes the unused-space code. The result goes into an output register that holds still while the downstream side stalls. The input side carries a dword count and a last-beat marker. The output side carries two start flags, two end flags and a 2-bit empty code. In each flag pair, bit 0 belongs to the lower half and bit 1 to the upper half.

Top module: `tlp_dual_slot_packer`

## Requirements
- R1: Every dword accepted on the input appears exactly once on the output, in arrival order. Dword k of a beat sits in bits [32k+31:32k], and lanes are filled from lane 0 upward.
- R2: A packet begins only in lane 0 or lane 4. `out_sop[0]` marks a start in lane 0 and `out_sop[1]` a start in lane 4. `out_sop[0]` is low on a beat whose lane 0 continues a packet from the previous beat.
- R3: `out_sop[1]` is raised only on a beat whose lower half ends a packet (`out_eop[0]` high), so one beat can carry both an end and a new start.
- R4: A packet ends in lower lane p and the next packet is already buffered, either its first four dwords or all of it. In that case the next packet starts in lane 4 of the same beat, taking the dwords in order from lane 4.
- R5: A packet ends in the lower half and the next packet is not buffered that far. In that case the upper lanes are driven to zero, and `out_sop[1]` and `out_eop[1]` are low.
- R6: `out_eop[0]` or `out_eop[1]` marks the half that holds a packet's final dword. After an end in the upper half, the next packet starts in lane 0 of a later beat.
- R7: On a beat with an end flag, `out_empty` equals floor((7 - highest occupied lane) / 2). On other beats it is 0.
- R8: A beat with no end flag has all eight lanes occupied.
- R9: While `out_valid` is high and `out_ready` is low, the data, flags and empty code stay unchanged and `out_valid` stays high.
- R10: `in_ready` is high exactly when at least four free dword slots remain. `in_cnt` (1 to 4) gives the number of valid low dwords in an input beat. `in_last` marks dword `in_cnt`-1 as the last dword of its packet.
- R11: After reset, `out_valid`, `out_sop` and `out_eop` are low and `in_ready` is high.
- R12: With `out_ready` held high, a continuous stream of full four-dword input beats is accepted without `in_ready` ever dropping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Room for a full input beat |
| in_data | input | 128 | Input dwords, dword 0 in the low bits |
| in_cnt | input | 3 | Number of valid dwords in the beat (1 to 4) |
| in_last | input | 1 | Beat holds the packet's final dword |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 256 | Eight dword lanes |
| out_sop | output | 2 | Packet start in lane 0 (bit 0) or lane 4 (bit 1) |
| out_eop | output | 2 | Packet end in lower (bit 0) or upper (bit 1) half |
| out_empty | output | 2 | Unused tail in two-dword units on ending beats |

## Verification
On every cycle, the assertions check the following:
- The output beat stays frozen while it is stalled.
- An upper-half start never appears without a lower-half end.
- An idle upper half is zero and carries no flags.
- The empty code is zero on beats with no end.
- The dword store never overflows or underflows.

Other behaviours can only be shown by the bench's scenarios, because they depend on what is buffered when a beat is formed. These are:
- whether a waiting packet is actually pulled into the upper half;
- whether the dword order survives random lengths and stalls;
- whether the empty code matches the true last lane;
- whether a continuous stream is taken without backpressure.

The bench builds those scenarios from stalled and random traffic and rebuilds every accepted beat from a queue of the dwords it sent.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;

   // Unused tail of a beat, in two-dword units, given its highest occupied lane.
   function automatic int tail_units(input int last_lane, input int lanes);
      return (lanes - 1 - last_lane) / 2;
   endfunction

   // Lane index where the second packet slot begins.
   function automatic int upper_slot(input int lanes);
      return lanes / 2;
   endfunction

endpackage

// File: rtl/tlp_dword_ring.sv
module tlp_dword_ring #(
   parameter int DW        = 32,
   parameter int DEPTH     = 16,
   parameter int IN_LANES  = 4,
   parameter int OUT_LANES = 8,
   parameter int CW        = 5,
   parameter int ICW       = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [ICW-1:0]            push_cnt,
   input  logic [IN_LANES*DW-1:0]    push_data,
   input  logic                      push_last,
   input  logic [CW-1:0]             pop_n,
   output logic [CW-1:0]             fill,
   output logic [OUT_LANES*DW-1:0]   win_data,
   output logic [OUT_LANES-1:0]      win_last,
   output logic                      has_room
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] store_q [DEPTH];
   logic          mark_q  [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] fill_q;

   always_ff @(posedge clk) begin
      for (int i = 0; i < IN_LANES; i++) begin
         if (push && i < int'(push_cnt)) begin
            store_q[wr_ptr + AW'(i)] <= push_data[i*DW +: DW];
            mark_q[wr_ptr + AW'(i)]  <= push_last && (i == int'(push_cnt) - 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         fill_q <= '0;
      end else begin
         wr_ptr <= wr_ptr + (push ? AW'(push_cnt) : '0);
         rd_ptr <= rd_ptr + AW'(pop_n);
         fill_q <= fill_q + (push ? CW'(push_cnt) : '0) - pop_n;
      end
   end

   for (genvar k = 0; k < OUT_LANES; k++) begin : g_win
      assign win_data[k*DW +: DW] = store_q[rd_ptr + AW'(k)];
      assign win_last[k]          = mark_q[rd_ptr + AW'(k)];
   end

   assign fill     = fill_q;
   assign has_room = fill_q <= CW'(DEPTH - IN_LANES);

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (int'(fill_q) + int'(push_cnt) <= DEPTH));

   a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_n <= fill_q);

endmodule

// File: rtl/tlp_slot_former.sv
module tlp_slot_former
   import tlp_pack_pkg::*;
#(
   parameter int DW        = 32,
   parameter int OUT_LANES = 8,
   parameter int CW        = 5,
   parameter int EW        = 2
) (
   input  logic [OUT_LANES*DW-1:0] win_data,
   input  logic [OUT_LANES-1:0]    win_last,
   input  logic [CW-1:0]           fill,
   input  logic                    mid_i,
   output logic                    fire,
   output logic [CW-1:0]           pop_n,
   output logic [OUT_LANES*DW-1:0] beat_data,
   output logic [1:0]              beat_sop,
   output logic [1:0]              beat_eop,
   output logic [EW-1:0]           beat_empty,
   output logic                    mid_o
);
   localparam int HALF = upper_slot(OUT_LANES);

   int   avail, end_lo, end_hi, top_lane, take, src;
   logic got_lo, got_hi, shift;

   always_comb begin
      avail  = int'(fill);
      got_lo = 1'b0;
      end_lo = 0;
      for (int i = 0; i < OUT_LANES; i++) begin
         if (!got_lo && i < avail && win_last[i]) begin
            got_lo = 1'b1;
            end_lo = i;
         end
      end

      got_hi = 1'b0;
      end_hi = 0;
      if (got_lo && end_lo < HALF) begin
         for (int j = 0; j < HALF; j++) begin
            if (!got_hi && (end_lo + 1 + j) < avail && win_last[end_lo + 1 + j]) begin
               got_hi = 1'b1;
               end_hi = HALF + j;
            end
         end
      end

      fire     = 1'b0;
      shift    = 1'b0;
      top_lane = 0;
      take     = 0;
      beat_sop = 2'b00;
      beat_eop = 2'b00;
      mid_o    = mid_i;

      if (got_lo && end_lo < HALF) begin
         fire        = 1'b1;
         beat_eop[0] = 1'b1;
         shift       = got_hi || (avail >= end_lo + 1 + HALF);
         if (shift) begin
            beat_sop[1] = 1'b1;
            beat_eop[1] = got_hi;
            top_lane    = got_hi ? end_hi : OUT_LANES - 1;
            take        = got_hi ? (end_lo + 2 + end_hi - HALF) : (end_lo + 1 + HALF);
            mid_o       = !got_hi;
         end else begin
            top_lane = end_lo;
            take     = end_lo + 1;
            mid_o    = 1'b0;
         end
      end else if (got_lo) begin
         fire        = 1'b1;
         beat_eop[1] = 1'b1;
         top_lane    = end_lo;
         take        = end_lo + 1;
         mid_o       = 1'b0;
      end else if (avail >= OUT_LANES) begin
         fire     = 1'b1;
         top_lane = OUT_LANES - 1;
         take     = OUT_LANES;
         mid_o    = 1'b1;
      end

      beat_sop[0] = fire && !mid_i;

      src = 0;
      for (int j = 0; j < OUT_LANES; j++) begin
         src = (shift && j >= HALF) ? (end_lo + 1 + j - HALF) : j;
         if (fire && j <= top_lane)
            beat_data[j*DW +: DW] = win_data[src*DW +: DW];
         else
            beat_data[j*DW +: DW] = '0;
      end

      pop_n      = CW'(take);
      beat_empty = (|beat_eop) ? EW'(tail_units(top_lane, OUT_LANES)) : '0;
   end

endmodule

// File: rtl/tlp_dual_slot_packer.sv
module tlp_dual_slot_packer
   import tlp_pack_pkg::*;
#(
   parameter int DW        = 32,
   parameter int IN_LANES  = 4,
   parameter int OUT_LANES = 8,
   parameter int DEPTH     = 16,
   localparam int ICW      = $clog2(IN_LANES + 1),
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int EW       = $clog2(OUT_LANES / 2)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [IN_LANES*DW-1:0]  in_data,
   input  logic [ICW-1:0]          in_cnt,
   input  logic                    in_last,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [OUT_LANES*DW-1:0] out_data,
   output logic [1:0]              out_sop,
   output logic [1:0]              out_eop,
   output logic [EW-1:0]           out_empty
);
   localparam int HALF = upper_slot(OUT_LANES);

   if (OUT_LANES < 4 || (OUT_LANES & (OUT_LANES - 1)) != 0) begin : g_bad_lanes
      $error("OUT_LANES must be a power of two of at least 4");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < OUT_LANES + IN_LANES) begin : g_bad_depth
      $error("DEPTH must be a power of two no smaller than OUT_LANES + IN_LANES");
   end
   if (IN_LANES < 1 || IN_LANES > OUT_LANES) begin : g_bad_in
      $error("IN_LANES must lie between 1 and OUT_LANES");
   end

   logic                    push, load, fire, mid_q, mid_nxt;
   logic [CW-1:0]           fill, pop_c, pop_n;
   logic [OUT_LANES*DW-1:0] win_data, beat_data;
   logic [OUT_LANES-1:0]    win_last;
   logic [1:0]              beat_sop, beat_eop;
   logic [EW-1:0]           beat_empty;

   assign push  = in_valid && in_ready;
   assign load  = !out_valid || out_ready;
   assign pop_n = (load && fire) ? pop_c : '0;

   tlp_dword_ring #(
      .DW(DW), .DEPTH(DEPTH), .IN_LANES(IN_LANES),
      .OUT_LANES(OUT_LANES), .CW(CW), .ICW(ICW)
   ) u_ring (
      .clk(clk), .rst_n(rst_n), .push(push), .push_cnt(in_cnt),
      .push_data(in_data), .push_last(in_last), .pop_n(pop_n),
      .fill(fill), .win_data(win_data), .win_last(win_last),
      .has_room(in_ready)
   );

   tlp_slot_former #(
      .DW(DW), .OUT_LANES(OUT_LANES), .CW(CW), .EW(EW)
   ) u_former (
      .win_data(win_data), .win_last(win_last), .fill(fill), .mid_i(mid_q),
      .fire(fire), .pop_n(pop_c), .beat_data(beat_data), .beat_sop(beat_sop),
      .beat_eop(beat_eop), .beat_empty(beat_empty), .mid_o(mid_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= '0;
         out_eop   <= '0;
         out_empty <= '0;
         mid_q     <= 1'b0;
      end else if (load) begin
         out_valid <= fire;
         if (fire) begin
            out_data  <= beat_data;
            out_sop   <= beat_sop;
            out_eop   <= beat_eop;
            out_empty <= beat_empty;
            mid_q     <= mid_nxt;
         end
      end
   end

   a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                  && $stable(out_eop) && $stable(out_empty));

   a_r3_upper_start_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sop[1] |-> out_eop[0]);

   a_r5_idle_upper: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_eop[0] && !out_sop[1]
         |-> out_data[OUT_LANES*DW-1 : HALF*DW] == '0 && !out_eop[1]);

   a_r7_empty_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(|out_eop) |-> out_empty == '0);

   a_r10_cnt_legal: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (in_cnt != '0 && int'(in_cnt) <= IN_LANES));

endmodule

// File: tb/tb_tlp_dual_slot_packer.sv
`timescale 1ns/1ps
module tb_tlp_dual_slot_packer;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         in_ready;
   logic [127:0] in_data;
   logic [2:0]   in_cnt;
   logic         in_last;
   logic         out_valid;
   logic         out_ready;
   logic [255:0] out_data;
   logic [1:0]   out_sop, out_eop, out_empty;

   always #10 clk = ~clk;

   tlp_dual_slot_packer dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_cnt(in_cnt), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
   );

   int checks = 0, errors = 0, combos = 0, stalls = 0, cycles = 0;
   int ready_mode = 1;
   bit started = 0, exp_mid = 0;
   int pkt_id = 0;
   logic [31:0] exp_q[$];
   bit          exp_l[$];
   logic [1:0]   lg_sop[$], lg_eop[$], lg_emp[$];
   logic [255:0] lg_data[$];

   logic         pv_valid, pv_ready;
   logic [255:0] pv_data;
   logic [1:0]   pv_sop, pv_eop, pv_emp;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Rebuild one accepted beat from the sent-dword queue.
   task automatic check_beat();
      logic [31:0] d;
      bit l, end_lo, end_hi, open, data_ok;
      int last;
      logic [1:0] sop_exp, eop_exp, emp_exp;
      logic [31:0] bad_a, bad_e;
      data_ok = 1; bad_a = 0; bad_e = 0;
      end_lo = 0; end_hi = 0; open = 1; last = 7;
      sop_exp = {1'b0, !exp_mid};
      for (int k = 0; k < 8; k++) begin
         if (exp_q.size() == 0) begin data_ok = 0; break; end
         d = exp_q.pop_front(); l = exp_l.pop_front();
         if (out_data[k*32 +: 32] !== d) begin data_ok = 0; bad_a = out_data[k*32 +: 32]; bad_e = d; end
         if (l) begin
            last = k; open = 0;
            if (k < 4) end_lo = 1; else end_hi = 1;
            break;
         end
      end
      if (end_lo) begin
         if (out_sop[1]) begin
            sop_exp[1] = 1; combos++; open = 1; last = 7;
            for (int k = 4; k < 8; k++) begin
               if (exp_q.size() == 0) begin data_ok = 0; break; end
               d = exp_q.pop_front(); l = exp_l.pop_front();
               if (out_data[k*32 +: 32] !== d) begin data_ok = 0; bad_a = out_data[k*32 +: 32]; bad_e = d; end
               if (l) begin last = k; open = 0; end_hi = 1; break; end
            end
         end else begin
            chk(out_data[255:128] == '0, "R5", "idle upper lanes", out_data[255:128], 0);
         end
      end
      eop_exp = {end_hi, end_lo};
      emp_exp = (|eop_exp) ? 2'((7 - last) / 2) : 2'd0;
      chk(data_ok, "R1", "dword order", bad_a, bad_e);
      chk(out_sop == sop_exp, "R2", "start flags", out_sop, sop_exp);
      chk(out_eop == eop_exp, "R6", "end flags", out_eop, eop_exp);
      chk(out_empty == emp_exp, "R7", "empty code", out_empty, emp_exp);
      if (!end_lo && !end_hi)
         chk(out_eop == 0 && out_empty == 0, "R8", "full beat", {out_eop, out_empty}, 0);
      exp_mid = open;
   endtask

   always @(negedge clk) begin
      if (started) begin
         cycles++;
         if (pv_valid && !pv_ready)
            chk(out_valid && out_data == pv_data && out_sop == pv_sop && out_eop == pv_eop
                && out_empty == pv_emp, "R9", "stalled beat changed",
                {out_sop, out_eop, out_empty}, {pv_sop, pv_eop, pv_emp});
         case (ready_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = ($urandom % 2) == 0;
         endcase
         if (out_valid && out_ready) begin
            check_beat();
            lg_sop.push_back(out_sop); lg_eop.push_back(out_eop);
            lg_emp.push_back(out_empty); lg_data.push_back(out_data);
         end
         pv_valid = out_valid; pv_ready = out_ready; pv_data = out_data;
         pv_sop = out_sop; pv_eop = out_eop; pv_emp = out_empty;
         if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
         end
      end
   end

   // Sends one packet; called at a negedge, returns at a negedge.
   task automatic send_pkt(input int len, input bit rand_chunks, input bit gaps);
      int idx, c;
      idx = 0; pkt_id++;
      while (idx < len) begin
         c = (len - idx < 4) ? len - idx : 4;
         if (rand_chunks) c = 1 + ($urandom % c);
         in_valid = 1'b1; in_cnt = 3'(c); in_last = (idx + c == len); in_data = '0;
         for (int i = 0; i < c; i++) in_data[i*32 +: 32] = {16'(pkt_id), 16'(idx + i)};
         while (!in_ready) begin stalls++; @(negedge clk); end
         for (int i = 0; i < c; i++) begin
            exp_q.push_back({16'(pkt_id), 16'(idx + i)});
            exp_l.push_back(idx + i == len - 1);
         end
         idx += c;
         @(negedge clk);
         in_valid = 1'b0;
         if (gaps) repeat ($urandom % 3) @(negedge clk);
      end
   endtask

   task automatic expect_beat(input int b, input logic [1:0] s, input logic [1:0] e,
                              input logic [1:0] m, input string req);
      if (lg_sop.size() <= b) begin
         chk(0, req, "missing beat", lg_sop.size(), b + 1);
      end else begin
         chk(lg_sop[b] == s, req, "beat start flags", lg_sop[b], s);
         chk(lg_eop[b] == e, req, "beat end flags", lg_eop[b], e);
         chk(lg_emp[b] == m, req, "beat empty", lg_emp[b], m);
      end
   endtask

   task automatic drain();
      ready_mode = 1;
      for (int i = 0; i < 400 && (exp_q.size() != 0 || out_valid); i++) @(negedge clk);
      chk(exp_q.size() == 0, "R1", "undelivered dwords", exp_q.size(), 0);
   endtask

   task automatic clear_log();
      lg_sop.delete(); lg_eop.delete(); lg_emp.delete(); lg_data.delete();
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_cnt = '0; in_last = 1'b0; in_data = '0;
      out_ready = 1'b1;
      pv_valid = 0; pv_ready = 1; pv_data = '0; pv_sop = 0; pv_eop = 0; pv_emp = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      started = 1;
      chk(out_valid == 0, "R11", "valid after reset", out_valid, 0);
      chk(in_ready == 1, "R11", "ready after reset", in_ready, 1);
      chk(out_sop == 0 && out_eop == 0, "R11", "flags after reset", {out_sop, out_eop}, 0);

      // R4: 3-dword packet followed by buffered 6-dword packet, behind a stalled beat.
      ready_mode = 0;
      send_pkt(8, 0, 0); send_pkt(3, 0, 0); send_pkt(6, 0, 0);
      repeat (6) @(negedge clk);
      clear_log(); ready_mode = 1;
      repeat (8) @(negedge clk);
      expect_beat(0, 2'b01, 2'b10, 2'd0, "R6");
      expect_beat(1, 2'b11, 2'b01, 2'd0, "R4");
      expect_beat(2, 2'b00, 2'b01, 2'd3, "R5");
      if (lg_data.size() > 1)
         chk(lg_data[1][159:128] == {16'(pkt_id), 16'd0}, "R4", "upper slot first dword",
             lg_data[1][159:128], {16'(pkt_id), 16'd0});
      if (lg_data.size() > 2)
         chk(lg_data[2][255:128] == '0, "R5", "idle upper after lone end", lg_data[2][255:128], 0);
      drain();

      // R6: packet ending in lane 5 pushes the next one to lane 0 of a new beat.
      ready_mode = 0;
      send_pkt(6, 0, 0); send_pkt(2, 0, 0);
      repeat (6) @(negedge clk);
      clear_log(); ready_mode = 1;
      repeat (6) @(negedge clk);
      expect_beat(0, 2'b01, 2'b10, 2'd1, "R6");
      expect_beat(1, 2'b01, 2'b01, 2'd3, "R7");
      drain();

      // R3: one-dword and two-dword packets share a beat, ends in both halves.
      ready_mode = 0;
      send_pkt(8, 0, 0); send_pkt(1, 0, 0); send_pkt(2, 0, 0);
      repeat (6) @(negedge clk);
      clear_log(); ready_mode = 1;
      repeat (6) @(negedge clk);
      expect_beat(1, 2'b11, 2'b11, 2'd1, "R3");
      drain();

      // R12: continuous full input beats with the output always ready.
      stalls = 0;
      send_pkt(64, 0, 0); send_pkt(12, 0, 0);
      chk(stalls == 0, "R12", "input stalls in continuous stream", stalls, 0);
      drain();

      // R10: with output blocked, input backpressure appears once storage is short.
      ready_mode = 0; stalls = 0;
      fork
         send_pkt(40, 0, 0);
         begin repeat (30) @(negedge clk); ready_mode = 1; end
      join
      chk(stalls > 0, "R10", "no backpressure with output blocked", stalls, 1);
      drain();

      // Random lengths, chunking, gaps and ready stalls.
      combos = 0;
      ready_mode = 2;
      for (int n = 0; n < 300; n++) send_pkt(1 + ($urandom % 20), 1, ($urandom % 2) == 0);
      drain();
      chk(combos > 0, "R3", "no same-beat end/start seen", combos, 1);

      summary();
   end

endmodule